// File: doc/BRIEF.md
# Stereo Volume and Cosine Soft-Mute Gain Stage

This block sits in a playback path and scales every accepted 24-bit stereo sample pair by two gains: a volume gain that follows a dB-linear attenuation setting in 1 dB steps, and an envelope gain. The envelope gain follows a raised-cosine curve between silence and unity. The envelope moves in 32 level steps. A soft-mute request moves it slowly, one level every 32 samples, so a full fade takes 1024 samples. Turning the converter on or off moves it quickly, one level every 4 samples, so a full fade takes 128 samples. When the fade that follows power removal reaches silence, a flag tells the analog stage it may be switched off.

A control-interface mode flag (`ctrl_en`) enables the sound processing. When it is low, samples pass through unchanged and the mute request is ignored. The power ramp still runs and the done flag still works. The envelope is driven by a state machine with these states: OFF (silent, powered down, done flag high), PWR_UP (fast rise), PLAY (unity envelope), MUTE_DN (slow fall), MUTED (silent, powered), MUTE_UP (slow rise) and PWR_DN (fast fall). The transitions are as follows:
- OFF goes to PWR_UP on power-on.
- PLAY goes to PWR_DN on power-off and to MUTE_DN on an effective mute.
- MUTED goes to OFF on power-off and to MUTE_UP on mute release.
- PWR_UP and MUTE_UP go to PWR_DN on power-off and to MUTE_DN on mute. They go to PLAY at the top level.
- MUTE_DN goes to PWR_DN on power-off, to MUTE_UP on release and to MUTED at level 0.
- PWR_DN goes to PWR_UP on power-on and to OFF at level 0.

Top module: `audio_gain_ramp`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the outputs then hold that sample's result.
- R2: With `ctrl_en` low, the outputs equal the inputs, whatever the volume and mute settings.
- R3: For an attenuation `a` from 0 to 60 the volume gain is F[a mod 6] >> (a div 6), where F[r] = round(32768·10^(-r/20)). For any `a` above 60 the output is zero.
- R4: At envelope level L (0..32) the envelope gain is round(32768·(1−cos(πL/32))/2), so level 0 is silence and level 32 is unity (32768).
- R5: Each output equals the input times the volume gain times the envelope gain, plus 2^29, arithmetically shifted right by 30 and saturated to 24 bits. Both channels of a pair use the same gains.
- R6: After reset the block is powered down at level 0, `pwr_ramp_done` is 1 and `out_valid` is 0.
- R7: After power-on, the k-th accepted sample uses level min(32, (k−1) div 4).
- R8: After power-off from level 32, the k-th accepted sample uses level 32 − (k−1) div 4. `pwr_ramp_done` rises right after the 128th sample and not before.
- R9: An enabled mute request from level 32 gives the k-th sample level 32 − (k−1) div 32, and the level stays at 0 after 1024 samples. After release from 0 the j-th sample uses level min(32, (j−1) div 32).
- R10: A reversal of ramp direction keeps the current level and restarts the dwell count, so the next level change comes one full dwell later.
- R11: `pwr_ramp_done` falls one cycle after `pwr_on` rises.
- R12: A mute request while `ctrl_en` is low leaves the envelope level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample pair present this cycle |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| vol_atten | input | 8 | Attenuation in dB, 1 dB per code |
| mute_req | input | 1 | Soft-mute request |
| ctrl_en | input | 1 | Sound-processing enable mode flag |
| pwr_on | input | 1 | Converter power state, 1 = on |
| out_valid | output | 1 | Scaled pair valid |
| out_left | output | 24 | Left scaled sample |
| out_right | output | 24 | Right scaled sample |
| pwr_ramp_done | output | 1 | Power-down fade finished, block silent |

## Verification
A scaled pair is due one cycle after it is accepted. The envelope level used for that pair is the level held before the accepting edge. A level step therefore shows first on the next sample. State changes caused by `pwr_on`, `mute_req` or `ctrl_en` take one clock. The bench therefore changes those controls and then idles one cycle before sending samples. Samples are driven on a falling edge and checked on the next falling edge, and the expected level of each sample is computed from its index within the ramp. `pwr_ramp_done` is sampled after every power-down sample, so that it is seen to rise exactly after the 128th.

// File: rtl/gain_pkg.sv
package gain_pkg;

    typedef enum logic [2:0] {
        RS_OFF,
        RS_PWR_UP,
        RS_PLAY,
        RS_MUTE_DN,
        RS_MUTED,
        RS_MUTE_UP,
        RS_PWR_DN
    } ramp_state_e;

    // Q15 raised-cosine envelope value for level k of steps
    function automatic int cos_q15(input int k, input int steps);
        real ang;
        ang = 3.14159265358979 * real'(k) / real'(steps);
        return $rtoi(32768.0 * (1.0 - $cos(ang)) / 2.0 + 0.5);
    endfunction

    // Q15 linear gain for an attenuation of r dB (0..5)
    function automatic int db_q15(input int r);
        real g;
        g = 10.0 ** (-real'(r) / 20.0);
        return $rtoi(32768.0 * g + 0.5);
    endfunction

endpackage

// File: rtl/gain_vol_lut.sv
module gain_vol_lut #(
    parameter int AW    = 8,
    parameter int GW    = 16,
    parameter int MAXDB = 60
) (
    input  logic [AW-1:0] atten,
    output logic [GW-1:0] vgain
);
    localparam int SUBS = 6;

    logic [GW-1:0] frac_tab [SUBS];
    logic [AW-1:0] whole;
    logic [2:0]    sub;

    for (genvar r = 0; r < SUBS; r++) begin : g_frac
        assign frac_tab[r] = GW'(gain_pkg::db_q15(r));
    end

    always_comb begin
        whole = atten / AW'(SUBS);
        sub   = 3'(atten % AW'(SUBS));
        if (atten > AW'(MAXDB)) vgain = '0;
        else                    vgain = frac_tab[sub] >> whole;
    end
endmodule

// File: rtl/gain_scale.sv
module gain_scale #(
    parameter int DW = 24,
    parameter int GW = 16
) (
    input  logic signed [DW-1:0] din,
    input  logic        [GW-1:0] vgain,
    input  logic        [GW-1:0] cgain,
    output logic signed [DW-1:0] dout
);
    localparam int PW = DW + 2 * (GW + 1);
    localparam int SH = 2 * (GW - 1);
    localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        prod = PW'(din) * PW'($signed({1'b0, vgain})) * PW'($signed({1'b0, cgain}));
        rnd  = (prod + HALF) >>> SH;
        if (rnd > MAXV)      dout = MAXV[DW-1:0];
        else if (rnd < MINV) dout = MINV[DW-1:0];
        else                 dout = rnd[DW-1:0];
    end
endmodule

// File: rtl/gain_ramp_fsm.sv
module gain_ramp_fsm #(
    parameter int STEPS      = 32,
    parameter int PWR_DWELL  = 4,
    parameter int MUTE_DWELL = 32,
    parameter int GW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          pwr_on,
    input  logic          mute_eff,
    output logic [GW-1:0] cgain,
    output logic          done
);
    import gain_pkg::*;

    localparam int LW   = $clog2(STEPS + 1);
    localparam int MAXD = (PWR_DWELL > MUTE_DWELL) ? PWR_DWELL : MUTE_DWELL;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [LW-1:0] TOP = LW'(STEPS);

    ramp_state_e   st, st_n;
    logic [LW-1:0] lvl, lvl_n;
    logic [CW-1:0] cnt, cnt_n, last;
    logic [GW-1:0] cos_tab [STEPS+1];

    for (genvar k = 0; k <= STEPS; k++) begin : g_cos
        assign cos_tab[k] = GW'(gain_pkg::cos_q15(k, STEPS));
    end

    always_comb begin
        last  = (st == RS_PWR_UP || st == RS_PWR_DN) ? CW'(PWR_DWELL - 1) : CW'(MUTE_DWELL - 1);
        st_n  = st;
        lvl_n = lvl;
        cnt_n = cnt;
        unique case (st)
            RS_OFF: if (pwr_on) begin st_n = RS_PWR_UP; cnt_n = '0; end
            RS_PLAY: begin
                if (!pwr_on)       begin st_n = RS_PWR_DN;  cnt_n = '0; end
                else if (mute_eff) begin st_n = RS_MUTE_DN; cnt_n = '0; end
            end
            RS_MUTED: begin
                if (!pwr_on)        st_n = RS_OFF;
                else if (!mute_eff) begin st_n = RS_MUTE_UP; cnt_n = '0; end
            end
            RS_PWR_UP, RS_MUTE_UP: begin
                if (!pwr_on)        begin st_n = RS_PWR_DN;  cnt_n = '0; end
                else if (mute_eff)  begin st_n = RS_MUTE_DN; cnt_n = '0; end
                else if (lvl == TOP) st_n = RS_PLAY;
                else if (smp_valid) begin
                    if (cnt == last) begin
                        cnt_n = '0;
                        lvl_n = lvl + 1'b1;
                        if (lvl_n == TOP) st_n = RS_PLAY;
                    end else cnt_n = cnt + 1'b1;
                end
            end
            RS_MUTE_DN: begin
                if (!pwr_on)         begin st_n = RS_PWR_DN; cnt_n = '0; end
                else if (!mute_eff)  begin st_n = RS_MUTE_UP; cnt_n = '0; end
                else if (lvl == '0)  st_n = RS_MUTED;
                else if (smp_valid) begin
                    if (cnt == last) begin
                        cnt_n = '0;
                        lvl_n = lvl - 1'b1;
                        if (lvl_n == '0) st_n = RS_MUTED;
                    end else cnt_n = cnt + 1'b1;
                end
            end
            RS_PWR_DN: begin
                if (pwr_on)          begin st_n = RS_PWR_UP; cnt_n = '0; end
                else if (lvl == '0)  st_n = RS_OFF;
                else if (smp_valid) begin
                    if (cnt == last) begin
                        cnt_n = '0;
                        lvl_n = lvl - 1'b1;
                        if (lvl_n == '0) st_n = RS_OFF;
                    end else cnt_n = cnt + 1'b1;
                end
            end
            default: st_n = RS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= RS_OFF;
            lvl <= '0;
            cnt <= '0;
        end else begin
            st  <= st_n;
            lvl <= lvl_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        done  = (st == RS_OFF);
        cgain = cos_tab[lvl];
    end

    // R4: level never leaves the table
    p_level_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= TOP);
    // R7: level only moves on an accepted sample
    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(lvl));
    // R10: level moves at most one step per sample
    p_level_unit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (lvl == $past(lvl) || lvl == $past(lvl) + 1'b1 || lvl + 1'b1 == $past(lvl)));
    // R8: done only while silent
    p_done_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lvl == '0);
    // R11: done drops one cycle after power-on
    p_done_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pwr_on) |=> !done);
endmodule

// File: rtl/audio_gain_ramp.sv
module audio_gain_ramp #(
    parameter int DW         = 24,
    parameter int AW         = 8,
    parameter int GW         = 16,
    parameter int MAXDB      = 60,
    parameter int STEPS      = 32,
    parameter int PWR_DWELL  = 4,
    parameter int MUTE_DWELL = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_left,
    input  logic signed [DW-1:0] in_right,
    input  logic        [AW-1:0] vol_atten,
    input  logic                 mute_req,
    input  logic                 ctrl_en,
    input  logic                 pwr_on,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_left,
    output logic signed [DW-1:0] out_right,
    output logic                 pwr_ramp_done
);
    localparam int NCH = 2;

    logic [GW-1:0]        vgain, cgain;
    logic signed [DW-1:0] ch_in  [NCH];
    logic signed [DW-1:0] ch_out [NCH];

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    gain_vol_lut #(.AW(AW), .GW(GW), .MAXDB(MAXDB)) u_vol (
        .atten (vol_atten),
        .vgain (vgain)
    );

    gain_ramp_fsm #(.STEPS(STEPS), .PWR_DWELL(PWR_DWELL), .MUTE_DWELL(MUTE_DWELL), .GW(GW)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (in_valid),
        .pwr_on    (pwr_on),
        .mute_eff  (mute_req & ctrl_en),
        .cgain     (cgain),
        .done      (pwr_ramp_done)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gain_scale #(.DW(DW), .GW(GW)) u_scale (
            .din   (ch_in[c]),
            .vgain (vgain),
            .cgain (cgain),
            .dout  (ch_out[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= ctrl_en ? ch_out[0] : in_left;
                out_right <= ctrl_en ? ch_out[1] : in_right;
            end
        end
    end

    // R1: one-cycle valid latency
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: bypass passes samples unchanged
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctrl_en) |=> (out_left == $past(in_left) && out_right == $past(in_right)));
    // R3: attenuation beyond range silences
    p_vol_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl_en && vol_atten > AW'(MAXDB)) |=> (out_left == '0 && out_right == '0));
endmodule

// File: tb/audio_gain_ramp_bench.sv
module audio_gain_ramp_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [23:0] in_left = '0, in_right = '0;
    logic [7:0] vol_atten = '0;
    logic mute_req = 1'b0, ctrl_en = 1'b1, pwr_on = 1'b0;
    logic out_valid, pwr_ramp_done;
    logic signed [23:0] out_left, out_right;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    localparam int SA = 3000001;
    localparam int SB = -7654321;

    always #2 clk = ~clk;

    audio_gain_ramp u_audio_gain_ramp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .vol_atten(vol_atten), .mute_req(mute_req), .ctrl_en(ctrl_en), .pwr_on(pwr_on),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .pwr_ramp_done(pwr_ramp_done)
    );

    function automatic int cgain(input int k);
        real ang;
        ang = 3.14159265358979 * real'(k) / real'(32);
        return $rtoi(32768.0 * (1.0 - $cos(ang)) / 2.0 + 0.5);
    endfunction

    function automatic int vgain(input int a);
        real g;
        if (a > 60) return 0;
        g = 10.0 ** (-real'(a % 6) / 20.0);
        return $rtoi(32768.0 * g + 0.5) >> (a / 6);
    endfunction

    function automatic int scl(input int x, input int vg, input int cg);
        longint p;
        p = longint'(x) * longint'(vg) * longint'(cg);
        p = (p + (64'sd1 <<< 29)) >>> 30;
        if (p > 8388607) p = 8388607;
        if (p < -8388608) p = -8388608;
        return int'(p);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int l, input int r, input int el, input int er, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_left = 24'(l); in_right = 24'(r);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " R1 valid"}, int'(out_valid), 1);
        chk(int'(out_left) == el, {tag, " left"}, int'(out_left), el);
        chk(int'(out_right) == er, {tag, " right"}, int'(out_right), er);
    endtask

    task automatic send_lvl(input int lv, input string tag);
        send(SA, SB, scl(SA, 32768, cgain(lv)), scl(SB, 32768, cgain(lv)), tag);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk(pwr_ramp_done == 1'b1, "R6 done", int'(pwr_ramp_done), 1);
        chk(out_valid == 1'b0, "R6 valid", int'(out_valid), 0);
        // R1: no valid without input
        idle();
        chk(out_valid == 1'b0, "R1 idle", int'(out_valid), 0);

        // R11 done falls one cycle after power-on
        pwr_on = 1'b1;
        @(negedge clk);
        chk(pwr_ramp_done == 1'b0, "R11 done drop", int'(pwr_ramp_done), 0);

        // R7 power-up ramp, R4/R5 envelope values
        for (int k = 1; k <= 132; k++) begin
            int lv;
            lv = (k - 1) / 4;
            if (lv > 32) lv = 32;
            send_lvl(lv, "R7 pwr-up");
        end

        // R3 volume sweep incl. beyond range, R5 saturating extremes
        for (int a = 0; a <= 70; a++) begin
            vol_atten = 8'(a);
            send(SA, SB, scl(SA, vgain(a), 32768), scl(SB, vgain(a), 32768), "R3 vol");
            send(8388607, -8388608, scl(8388607, vgain(a), 32768), scl(-8388608, vgain(a), 32768), "R5 ext");
        end
        vol_atten = 8'd255;
        send(SA, SB, 0, 0, "R3 full mute");

        // R2 bypass with mute and volume set; R12 mute ignored
        ctrl_en = 1'b0; vol_atten = 8'd20; mute_req = 1'b1;
        idle();
        for (int k = 0; k < 40; k++) send(SA + k, SB - k, SA + k, SB - k, "R2 bypass");
        mute_req = 1'b0; ctrl_en = 1'b1; vol_atten = 8'd0;
        idle();
        send_lvl(32, "R12 level kept");

        // R9 soft mute partial, then R10 reversal
        mute_req = 1'b1;
        idle();
        for (int k = 1; k <= 100; k++) send_lvl(32 - (k - 1) / 32, "R9 mute dn");
        mute_req = 1'b0;
        idle();
        for (int j = 1; j <= 100; j++) begin
            int lv;
            lv = 29 + (j - 1) / 32;
            if (lv > 32) lv = 32;
            send_lvl(lv, "R10 mute rev");
        end

        // R9 full soft mute to silence and back
        mute_req = 1'b1;
        idle();
        for (int k = 1; k <= 1030; k++) begin
            int lv;
            lv = 32 - (k - 1) / 32;
            if (lv < 0) lv = 0;
            send_lvl(lv, "R9 full mute");
        end
        mute_req = 1'b0;
        idle();
        for (int j = 1; j <= 1030; j++) begin
            int lv;
            lv = (j - 1) / 32;
            if (lv > 32) lv = 32;
            send_lvl(lv, "R9 unmute");
        end

        // R8 power-down ramp and done timing
        pwr_on = 1'b0;
        idle();
        for (int k = 1; k <= 128; k++) begin
            send_lvl(32 - (k - 1) / 4, "R8 pwr-dn");
            chk(pwr_ramp_done == (k == 128), "R8 done", int'(pwr_ramp_done), int'(k == 128));
        end
        send_lvl(0, "R8 off silent");

        // R10 fast reversal mid power-up
        pwr_on = 1'b1;
        idle();
        for (int k = 1; k <= 10; k++) send_lvl((k - 1) / 4, "R10 pwr-up part");
        pwr_on = 1'b0;
        idle();
        for (int k = 1; k <= 8; k++) begin
            send_lvl(2 - (k - 1) / 4, "R10 pwr rev");
            chk(pwr_ramp_done == (k == 8), "R10 done", int'(pwr_ramp_done), int'(k == 8));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule